// File: doc/BRIEF.md
# Dual-Channel Sequential Mode Register Bank

Each of two channels holds three 8-bit mode registers (MR0, MR1, MR2) that share a single bus address. An internal selector decides which of the three a read or a write on that address reaches. After every access the selector moves one step forward: MR0 to MR1, MR1 to MR2, and then it stays on MR2. Software can move it back only by writing one of two codes to the channel's command address. The code 0xB0 selects MR0. The code 0x10 selects MR1.

A typical driver first writes the "select MR0" code. It then writes three bytes in a row to the mode address, and those land in MR0, MR1 and MR2 in that order. Reads work the same way. The bus uses single-cycle strobes on a 4-bit address. Read data is combinational and reflects the register selected before the access. The selector updates at the clock edge that ends the strobe. The values stored in all six registers are always visible on two packed output buses.

Top module: `mode_ptr_pair`

## Requirements
- R1: While rst_ni is low, every mode register reads 0x00 and each channel's selector is on MR1. The first access after reset therefore reaches MR1.
- R2: A write of 0xB0 to a channel's command address places that channel's selector on MR0 at the next clock edge.
- R3: A write of 0x10 to a channel's command address places that channel's selector on MR1 at the next clock edge.
- R4: Each read or write strobe on a channel's mode address reaches the register selected before the strobe. At the next edge the selector moves MR0 to MR1, or MR1 to MR2.
- R5: With the selector on MR2, further mode accesses keep it on MR2 and keep reaching MR2.
- R6: A command-address write of any code other than 0xB0 or 0x10 leaves the selector where it was.
- R7: Channel A uses mode address 0x0 and command address 0x2. Channel B uses 0x8 and 0xA. Accesses or commands on one channel never move the other channel's selector or change its registers.
- R8: rdata_o shows the selected register of the addressed channel while rd_i is high with a mode address. In every other case it shows 0x00.
- R9: mode_a_o and mode_b_o pack the registers as MR2 in bits 23:16, MR1 in bits 15:8 and MR0 in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| mode_a_o | output | 24 | Channel A {MR2, MR1, MR0} |
| mode_b_o | output | 24 | Channel B {MR2, MR1, MR0} |

## Verification
A selector in the wrong place shows up on the very next mode access. A read returns a different register's byte on rdata_o in that same cycle. A write lands in the wrong byte lane of mode_a_o or mode_b_o one edge later. The stimulus therefore follows every move of the selector with a read, or with a write whose destination lane is checked. Stray cross-channel effects are detected by reading the other channel after each command.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned AW  = 4;
  localparam int unsigned NCH = 2;
  localparam int unsigned NMR = 3;

  typedef enum logic [1:0] {
    SEL_MR0 = 2'd0,
    SEL_MR1 = 2'd1,
    SEL_MR2 = 2'd2
  } mr_sel_e;
endpackage

// File: rtl/mrp_ptr.sv
module mrp_ptr
  import mrp_pkg::*;
#(
  parameter logic [DW-1:0] CMD_MR0 = 8'hB0,
  parameter logic [DW-1:0] CMD_MR1 = 8'h10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] cmd_i,
  input  logic          acc_i,
  output mr_sel_e       sel_o
);
  mr_sel_e sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (cmd_we_i) begin
      if (cmd_i == CMD_MR0)      sel_d = SEL_MR0;
      else if (cmd_i == CMD_MR1) sel_d = SEL_MR1;
    end else if (acc_i) begin
      unique case (sel_q)
        SEL_MR0: sel_d = SEL_MR1;
        default: sel_d = SEL_MR2; // MR1 steps up, MR2 sticks
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SEL_MR1;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/mrp_bank.sv
module mrp_bank
  import mrp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  mr_sel_e         sel_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [NMR*DW-1:0] regs_o
);
  logic [DW-1:0] mr_q [NMR];

  for (genvar i = 0; i < NMR; i++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mr_q[i] <= '0;
      else if (we_i && sel_i == mr_sel_e'(i))   mr_q[i] <= wdata_i;
    end
    assign regs_o[i*DW +: DW] = mr_q[i];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NMR; i++)
      if (sel_i == mr_sel_e'(i)) rdata_o = mr_q[i];
  end
endmodule

// File: rtl/mrp_chan.sv
module mrp_chan
  import mrp_pkg::*;
#(
  parameter logic [AW-1:0] MODE_ADDR = 4'h0,
  parameter logic [AW-1:0] CMD_ADDR  = 4'h2,
  parameter logic [DW-1:0] CMD_MR0   = 8'hB0,
  parameter logic [DW-1:0] CMD_MR1   = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NMR*DW-1:0] regs_o,
  output mr_sel_e           sel_o
);
  logic mode_hit, acc, mode_we, cmd_we;
  logic [DW-1:0] bank_rdata;

  assign mode_hit = (addr_i == MODE_ADDR);
  assign acc      = mode_hit && (wr_i || rd_i);
  assign mode_we  = mode_hit && wr_i;
  assign cmd_we   = (addr_i == CMD_ADDR) && wr_i;

  mrp_ptr #(.CMD_MR0(CMD_MR0), .CMD_MR1(CMD_MR1)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_we_i(cmd_we),
    .cmd_i   (wdata_i),
    .acc_i   (acc),
    .sel_o   (sel_o)
  );

  mrp_bank i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mode_we),
    .sel_i  (sel_o),
    .wdata_i(wdata_i),
    .rdata_o(bank_rdata),
    .regs_o (regs_o)
  );

  assign rdata_o = (mode_hit && rd_i) ? bank_rdata : '0;
endmodule

// File: rtl/mode_ptr_pair.sv
module mode_ptr_pair
  import mrp_pkg::*;
#(
  parameter int unsigned   CH_STRIDE = 8,
  parameter int unsigned   MODE_OFS  = 0,
  parameter int unsigned   CMD_OFS   = 2,
  parameter logic [DW-1:0] CMD_MR0   = 8'hB0,
  parameter logic [DW-1:0] CMD_MR1   = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NMR*DW-1:0] mode_a_o,
  output logic [NMR*DW-1:0] mode_b_o
);
  logic [DW-1:0]     ch_rdata [NCH];
  logic [NMR*DW-1:0] ch_regs  [NCH];
  mr_sel_e           ch_sel   [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] M_ADDR = AW'(c * CH_STRIDE + MODE_OFS);
    localparam logic [AW-1:0] C_ADDR = AW'(c * CH_STRIDE + CMD_OFS);
    mrp_chan #(
      .MODE_ADDR(M_ADDR), .CMD_ADDR(C_ADDR),
      .CMD_MR0(CMD_MR0),  .CMD_MR1(CMD_MR1)
    ) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .addr_i (addr_i),
      .wr_i   (wr_i),
      .rd_i   (rd_i),
      .wdata_i(wdata_i),
      .rdata_o(ch_rdata[c]),
      .regs_o (ch_regs[c]),
      .sel_o  (ch_sel[c])
    );
  end

  // channels drive zero when not addressed
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) rdata_o |= ch_rdata[c];
  end

  assign mode_a_o = ch_regs[0];
  assign mode_b_o = ch_regs[1];
endmodule

// File: rtl/mrp_chk.sv
module mrp_chk
  import mrp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NMR*DW-1:0] mode_a_o,
  input logic [NMR*DW-1:0] mode_b_o,
  input mr_sel_e           sel_a,
  input mr_sel_e           sel_b
);
  logic acc_a, acc_b, cmd_a, cmd_b;
  assign acc_a = (addr_i == 4'h0) && (wr_i || rd_i);
  assign acc_b = (addr_i == 4'h8) && (wr_i || rd_i);
  assign cmd_a = (addr_i == 4'h2) && wr_i;
  assign cmd_b = (addr_i == 4'hA) && wr_i;

  // R2
  cmd_mr0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_a && wdata_i == 8'hB0 |=> sel_a == SEL_MR0);
  // R3
  cmd_mr1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_b && wdata_i == 8'h10 |=> sel_b == SEL_MR1);
  // R4
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_a && sel_a == SEL_MR0 |=> sel_a == SEL_MR1);
  // R5
  sticky_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_a && sel_a == SEL_MR2 |=> sel_a == SEL_MR2);
  // R6
  other_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_a && wdata_i != 8'hB0 && wdata_i != 8'h10 |=> $stable(sel_a));
  // R7
  chan_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_a || cmd_a) |=> $stable(sel_b) && $stable(mode_b_o));
  // R4
  write_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_a && wr_i && sel_a == SEL_MR1 |=> mode_a_o[15:8] == $past(wdata_i));
  // R8
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

bind mode_ptr_pair mrp_chk i_mrp_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .mode_a_o(mode_a_o),
  .mode_b_o(mode_b_o),
  .sel_a   (ch_sel[0]),
  .sel_b   (ch_sel[1])
);

// File: tb/test_mode_ptr_pair.sv
module test_mode_ptr_pair;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [23:0] mode_a_o, mode_b_o;
  int errors = 0, checks = 0;

  always #2 clk_i = ~clk_i;

  mode_ptr_pair i_mode_ptr_pair (.*);

  // {req[3:0], op[1:0] (1=wr 2=rd), addr[3:0], data[7:0], exp[7:0]}
  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    {4'd1, 2'd2, 4'h0, 8'h00, 8'h00}, // R1 first read hits MR1 -> MR2
    {4'd5, 2'd1, 4'h0, 8'h33, 8'h00}, // R5 write MR2
    {4'd5, 2'd2, 4'h0, 8'h00, 8'h33}, // R5 still MR2
    {4'd2, 2'd1, 4'h2, 8'hB0, 8'h00}, // R2 A -> MR0
    {4'd4, 2'd1, 4'h0, 8'h11, 8'h00}, // R4 MR0
    {4'd4, 2'd1, 4'h0, 8'h22, 8'h00}, // R4 MR1
    {4'd4, 2'd2, 4'h0, 8'h00, 8'h33}, // R4 MR2
    {4'd6, 2'd1, 4'h2, 8'h55, 8'h00}, // R6 other code
    {4'd6, 2'd2, 4'h0, 8'h00, 8'h33}, // R6 still MR2
    {4'd3, 2'd1, 4'h2, 8'h10, 8'h00}, // R3 A -> MR1
    {4'd3, 2'd2, 4'h0, 8'h00, 8'h22}, // R3 reads MR1
    {4'd7, 2'd1, 4'hA, 8'hB0, 8'h00}, // R7 B -> MR0
    {4'd7, 2'd2, 4'h0, 8'h00, 8'h33}, // R7 A untouched
    {4'd7, 2'd1, 4'h8, 8'h44, 8'h00}, // R7 B MR0
    {4'd7, 2'd2, 4'h8, 8'h00, 8'h00}, // R7 B MR1
    {4'd7, 2'd1, 4'h2, 8'hB0, 8'h00}, // R7 A -> MR0
    {4'd7, 2'd2, 4'h8, 8'h00, 8'h00}, // R7 B MR2 unaffected
    {4'd7, 2'd2, 4'h0, 8'h00, 8'h11}  // R7 A reads MR0
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample combinational read 1 ns later, strobe ends at posedge
  task automatic access(input logic wr, input logic rd, input logic [3:0] a,
                        input logic [7:0] d, output logic [7:0] rd_val);
    @(negedge clk_i);
    wr_i = wr; rd_i = rd; addr_i = a; wdata_i = d;
    #1 rd_val = rdata_o;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  initial begin
    logic [7:0] r;
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    chk("R1", mode_a_o, 24'h0);
    chk("R1", mode_b_o, 24'h0);
    rst_ni = 1'b1;
    access(1'b1, 1'b0, 4'h0, 8'h77, r);
    chk("R1", mode_a_o, 24'h007700);  // landed in MR1 (R9 lane)
    rst_ni = 1'b0; #1;
    chk("R1", mode_a_o, 24'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq; logic [1:0] op; logic [3:0] a; logic [7:0] d, e;
      {rq, op, a, d, e} = VEC[i];
      access(op == 2'd1, op == 2'd2, a, d, r);
      if (op == 2'd2) begin
        checks++;
        if (r !== e) begin
          errors++;
          $display("FAIL R%0d vec %0d actual=%h expected=%h", rq, i, r, e);
        end
      end
    end

    chk("R9", mode_a_o, 24'h332211);
    chk("R9", mode_b_o, 24'h000044);
    // R8: no strobe, and read of non-mode address, give zero
    @(negedge clk_i); addr_i = 4'h0; #1;
    chk("R8", {16'h0, rdata_o}, 24'h0);
    access(1'b0, 1'b1, 4'h2, 8'h00, r);
    chk("R8", {16'h0, r}, 24'h0);
    // R5: repeated writes at MR2 keep landing in MR2 (A now at MR1 after last read)
    access(1'b1, 1'b0, 4'h0, 8'hA1, r);
    access(1'b1, 1'b0, 4'h0, 8'hA2, r);
    access(1'b1, 1'b0, 4'h0, 8'hA3, r);
    chk("R5", mode_a_o, 24'hA3A111);
    rst_ni = 1'b0; #1;
    chk("R1", mode_a_o, 24'h0);
    chk("R1", mode_b_o, 24'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule